// File: doc/BRIEF.md
# Dual-Space Internal Data Memory

This block is the internal data memory of a small 8-bit controller core. It has a 256-byte scratchpad RAM and a separate window of special-function registers. The two overlap in the upper half of the address range. A mode flag sent with every generic access picks which space an upper address reaches. Direct accesses to the upper half go to the register window, and indirect accesses go to the upper scratchpad. The lower half is scratchpad in both modes.

Two more access paths reach the same RAM:

- **Working registers.** A bank select and a register index form the address. Four banks of eight bytes sit at the bottom of the scratchpad.
- **Hardware stack.** An up-counting stack pointer serves push and pop requests. Stack traffic always uses indirect addressing, so the stack may grow into the upper scratchpad.

The stack pointer is also one of the special-function registers. Two general example registers stand in for the real peripheral registers.

Each cycle carries at most one operation, chosen by fixed priority. Read results come back one cycle later, marked by a valid strobe.

Top module: `dmem_core`

## Requirements
- R1: After reset the stack pointer output is 07h and `rd_valid` is low.
- R2: For addresses 00h–7Fh, a byte written in one mode (direct or indirect) reads back unchanged in the other mode.
- R3: An indirect access (`acc_ind`=1) to 80h–FFh reaches the upper scratchpad, and no special-function register write changes it.
- R4: A direct access (`acc_ind`=0) to 80h–FFh reaches the special-function register window. The example registers at E0h and F0h read back the last value written to them.
- R5: A direct read of an unimplemented register address (anything other than 81h, E0h, F0h) returns FFh. A direct write there changes nothing.
- R6: A working-register access with bank `bank_sel`=b and index `reg_idx`=r reaches scratchpad address b*8+r. `reg_wr` takes precedence over `reg_rd`.
- R7: A push first increments the stack pointer, then writes `wr_data` to the scratchpad at the new pointer value.
- R8: A pop returns the scratchpad byte at the current stack pointer, then decrements the pointer.
- R9: The stack pointer wraps modulo 256 in both directions, and no overflow indication exists.
- R10: The stack pointer reads and writes as the direct register at 81h. It holds its value in any cycle without a push, pop or such write.
- R11: Read data appears on `rd_data` with `rd_valid` high exactly one cycle after the read request. One operation runs per cycle, with priority push, then pop, then working register, then generic access. Within a generic access, write beats read.
- R12: The example registers at E0h and F0h reset to 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 8 | Address of a generic access |
| acc_ind | input | 1 | 1 = indirect mode, 0 = direct mode |
| rd_en | input | 1 | Generic read request |
| wr_en | input | 1 | Generic write request |
| wr_data | input | 8 | Write data for generic, register and push writes |
| bank_sel | input | 2 | Active working-register bank |
| reg_idx | input | 3 | Working-register index within the bank |
| reg_rd | input | 1 | Working-register read request |
| reg_wr | input | 1 | Working-register write request |
| push_req | input | 1 | Stack push request |
| pop_req | input | 1 | Stack pop request |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | `rd_data` holds the result of last cycle's read |
| sp_out | output | 8 | Current stack pointer |

## Verification
A wrong stack pointer shows on `sp_out` on the edge after the faulty push, pop or load. It then corrupts the next pop's data and the address the next push writes.

A mode-decoding error shows up as a read from the wrong space, but only when the bench later reads that address back. The bench therefore reads each upper address in both modes right after writing it. A bad bank mapping or a lost priority appears as the wrong byte on a later read of the target location. A latency error shows up on the very next cycle as a `rd_valid` out of step with the request.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_WREG,
    OP_GEN
  } dmem_op_e;

endpackage

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) q <= mem[addr];
  end

endmodule

// File: rtl/dmem_stack.sv
module dmem_stack #(
  parameter int          AW       = 8,
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_up
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TOP = '1;

  assign sp_up = sp + ONE;

  always_ff @(posedge clk) begin
    if (rst)      sp <= SP_RESET;
    else if (inc) sp <= sp_up;
    else if (dec) sp <= sp - ONE;
    else if (ld)  sp <= ld_val;
  end

  AST_SP_RESET: assert property (@(posedge clk) rst |=> sp == SP_RESET); // R1
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    inc |=> sp == AW'($past(sp) + ONE)); // R7
  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc) |=> sp == AW'($past(sp) - ONE)); // R8
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (inc && sp == TOP) |=> sp == '0); // R9
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!inc && !dec && !ld) |=> $stable(sp)); // R10

endmodule

// File: rtl/dmem_sfr.sv
module dmem_sfr #(
  parameter int                  DW       = 8,
  parameter int                  AW       = 8,
  parameter int                  NUM_GP   = 2,
  parameter logic [NUM_GP*AW-1:0] GP_ADDRS = {8'hF0, 8'hE0},
  parameter logic [AW-1:0]       SP_ADDR  = 8'h81,
  parameter logic [DW-1:0]       FILL     = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] sp_val,
  output logic          sp_ld,
  output logic [AW-1:0] sp_ld_val,
  output logic [DW-1:0] q
);
  logic [NUM_GP-1:0] hit;
  logic [DW-1:0]     gp_q [NUM_GP];
  logic              sp_hit;
  logic              any_hit;
  logic [DW-1:0]     rd_mux;

  assign sp_hit    = (addr == SP_ADDR);
  assign sp_ld     = wr && sp_hit;
  assign sp_ld_val = AW'(wd);
  assign any_hit   = sp_hit || (|hit);

  for (genvar g = 0; g < NUM_GP; g++) begin : g_reg
    assign hit[g] = (addr == GP_ADDRS[g*AW +: AW]);
    always_ff @(posedge clk) begin
      if (rst)                 gp_q[g] <= '0;
      else if (wr && hit[g])   gp_q[g] <= wd;
    end
    AST_GP_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(wr && addr == GP_ADDRS[g*AW +: AW]) |=> $stable(gp_q[g])); // R4
  end

  always_comb begin
    rd_mux = FILL;
    if (sp_hit) rd_mux = DW'(sp_val);
    for (int i = 0; i < NUM_GP; i++) begin
      if (hit[i]) rd_mux = gp_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= FILL;
    else if (rd) q <= rd_mux;
  end

  AST_UNIMP_FILL: assert property (@(posedge clk) disable iff (rst)
    (rd && !any_hit) |=> q == FILL); // R5

endmodule

// File: rtl/dmem_core.sv
module dmem_core
  import dmem_pkg::*;
#(
  parameter int                   DW       = 8,
  parameter int                   AW       = 8,
  parameter int                   BANK_W   = 2,
  parameter int                   IDX_W    = 3,
  parameter logic [AW-1:0]        SP_RESET = 8'h07,
  parameter logic [AW-1:0]        SP_ADDR  = 8'h81,
  parameter int                   NUM_GP   = 2,
  parameter logic [NUM_GP*AW-1:0] GP_ADDRS = {8'hF0, 8'hE0},
  parameter logic [DW-1:0]        FILL     = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     acc_addr,
  input  logic              acc_ind,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              push_req,
  input  logic              pop_req,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic [AW-1:0]     sp_out
);
  localparam int PAD_W = AW - BANK_W - IDX_W;

  dmem_op_e      op;
  logic          to_sfr;
  logic          ram_we, ram_re, sfr_rd, sfr_wr;
  logic          st_inc, st_dec, rd_issue, rd_sfr;
  logic [AW-1:0] ram_addr, reg_addr, sp, sp_up, sp_ld_val;
  logic [DW-1:0] ram_q, sfr_q;
  logic          sp_ld;
  logic          src_sfr_q;

  assign reg_addr = {{PAD_W{1'b0}}, bank_sel, reg_idx};
  assign to_sfr   = !acc_ind && acc_addr[AW-1];

  always_comb begin
    if (push_req)              op = OP_PUSH;
    else if (pop_req)          op = OP_POP;
    else if (reg_rd || reg_wr) op = OP_WREG;
    else if (rd_en || wr_en)   op = OP_GEN;
    else                       op = OP_IDLE;
  end

  always_comb begin
    ram_we   = 1'b0;
    ram_re   = 1'b0;
    ram_addr = acc_addr;
    sfr_rd   = 1'b0;
    sfr_wr   = 1'b0;
    st_inc   = 1'b0;
    st_dec   = 1'b0;
    rd_issue = 1'b0;
    rd_sfr   = 1'b0;
    unique case (op)
      OP_PUSH: begin
        st_inc   = 1'b1;
        ram_we   = 1'b1;
        ram_addr = sp_up;
      end
      OP_POP: begin
        st_dec   = 1'b1;
        ram_re   = 1'b1;
        ram_addr = sp;
        rd_issue = 1'b1;
      end
      OP_WREG: begin
        ram_addr = reg_addr;
        ram_we   = reg_wr;
        ram_re   = !reg_wr;
        rd_issue = !reg_wr;
      end
      OP_GEN: begin
        rd_issue = !wr_en;
        if (to_sfr) begin
          sfr_wr = wr_en;
          sfr_rd = !wr_en;
          rd_sfr = 1'b1;
        end else begin
          ram_we = wr_en;
          ram_re = !wr_en;
        end
      end
      default: ;
    endcase
  end

  dmem_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .re   (ram_re),
    .addr (ram_addr),
    .wd   (wr_data),
    .q    (ram_q)
  );

  dmem_sfr #(
    .DW(DW), .AW(AW), .NUM_GP(NUM_GP), .GP_ADDRS(GP_ADDRS),
    .SP_ADDR(SP_ADDR), .FILL(FILL)
  ) u_sfr (
    .clk       (clk),
    .rst       (rst),
    .rd        (sfr_rd),
    .wr        (sfr_wr),
    .addr      (acc_addr),
    .wd        (wr_data),
    .sp_val    (sp),
    .sp_ld     (sp_ld),
    .sp_ld_val (sp_ld_val),
    .q         (sfr_q)
  );

  dmem_stack #(.AW(AW), .SP_RESET(SP_RESET)) u_stack (
    .clk    (clk),
    .rst    (rst),
    .inc    (st_inc),
    .dec    (st_dec),
    .ld     (sp_ld),
    .ld_val (sp_ld_val),
    .sp     (sp),
    .sp_up  (sp_up)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      src_sfr_q <= 1'b0;
    end else begin
      rd_valid  <= rd_issue;
      if (rd_issue) src_sfr_q <= rd_sfr;
    end
  end

  assign rd_data = src_sfr_q ? sfr_q : ram_q;
  assign sp_out  = sp;

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_issue |=> rd_valid); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !rd_issue |=> !rd_valid); // R11
  AST_ONE_OP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_inc, st_dec, sfr_wr, sfr_rd})); // R11
  AST_SFR_NO_RAM: assert property (@(posedge clk) disable iff (rst)
    (sfr_wr || sfr_rd) |-> !ram_we); // R3

endmodule

// File: tb/dmem_core_test.sv
module dmem_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc_addr = '0;
  logic       acc_ind = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] bank_sel = '0;
  logic [2:0] reg_idx = '0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0, push_req = 1'b0, pop_req = 1'b0;
  logic [7:0] rd_data, sp_out;
  logic       rd_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] ram_m [256];
  logic [7:0] gp_e0 = 8'h00, gp_f0 = 8'h00, sp_m = 8'h07;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  int         cyc_q [$];

  dmem_core uut (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_ind(acc_ind),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .bank_sel(bank_sel),
    .reg_idx(reg_idx), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .push_req(push_req), .pop_req(pop_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .sp_out(sp_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever the design presents read data
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: rd_valid with no read pending, got %02h expected none", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        automatic int         c = cyc_q.pop_front();
        check(t, rd_data, e);
        check("R11 latency", 8'(cyc - c), 8'd1);
      end
    end
  end

  task automatic clr();
    acc_addr = '0; acc_ind = 1'b0; rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    bank_sel = '0; reg_idx = '0; reg_rd = 1'b0; reg_wr = 1'b0;
    push_req = 1'b0; pop_req = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag); cyc_q.push_back(cyc);
  endtask

  function automatic logic [7:0] model_rd(input logic [7:0] a, input logic ind);
    if (!a[7] || ind) return ram_m[a];
    if (a == 8'h81) return sp_m;
    if (a == 8'hE0) return gp_e0;
    if (a == 8'hF0) return gp_f0;
    return 8'hFF;
  endfunction

  task automatic gen_wr(input logic [7:0] a, input logic ind, input logic [7:0] d);
    @(negedge clk); clr();
    acc_addr = a; acc_ind = ind; wr_en = 1'b1; wr_data = d;
    if (!a[7] || ind) ram_m[a] = d;
    else if (a == 8'h81) sp_m = d;
    else if (a == 8'hE0) gp_e0 = d;
    else if (a == 8'hF0) gp_f0 = d;
  endtask

  task automatic gen_rd(input logic [7:0] a, input logic ind, input string tag);
    @(negedge clk); clr();
    acc_addr = a; acc_ind = ind; rd_en = 1'b1;
    expect_rd(model_rd(a, ind), tag);
  endtask

  task automatic wreg_wr(input logic [1:0] b, input logic [2:0] r, input logic [7:0] d);
    @(negedge clk); clr();
    bank_sel = b; reg_idx = r; reg_wr = 1'b1; wr_data = d;
    ram_m[{3'b000, b, r}] = d;
  endtask

  task automatic wreg_rd(input logic [1:0] b, input logic [2:0] r, input string tag);
    @(negedge clk); clr();
    bank_sel = b; reg_idx = r; reg_rd = 1'b1;
    expect_rd(ram_m[{3'b000, b, r}], tag);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); clr();
    push_req = 1'b1; wr_data = d;
    sp_m = sp_m + 8'd1; ram_m[sp_m] = d;
  endtask

  task automatic pop(input string tag);
    @(negedge clk); clr();
    pop_req = 1'b1;
    expect_rd(ram_m[sp_m], tag);
    sp_m = sp_m - 8'd1;
  endtask

  task automatic sp_check(input string tag);
    @(negedge clk); clr();
    check(tag, sp_out, sp_m);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sp reset", sp_out, 8'h07);
    check("R1 valid reset", {7'b0, rd_valid}, 8'h00);

    gen_rd(8'hE0, 1'b0, "R12 E0 reset");
    gen_rd(8'hF0, 1'b0, "R12 F0 reset");

    gen_wr(8'h30, 1'b1, 8'hA5);
    gen_rd(8'h30, 1'b0, "R2 ind->dir");
    gen_wr(8'h45, 1'b0, 8'h3C);
    gen_rd(8'h45, 1'b1, "R2 dir->ind");
    gen_wr(8'h7F, 1'b0, 8'h81);
    gen_rd(8'h7F, 1'b1, "R2 top of lower half");

    gen_wr(8'h90, 1'b1, 8'h11);
    gen_wr(8'h90, 1'b0, 8'h77);
    gen_rd(8'h90, 1'b1, "R3 upper RAM kept");
    gen_rd(8'h90, 1'b0, "R5 unimpl reads FF");
    gen_wr(8'hE0, 1'b1, 8'hC3);
    gen_wr(8'hE0, 1'b0, 8'h5A);
    gen_rd(8'hE0, 1'b0, "R4 E0 direct");
    gen_rd(8'hE0, 1'b1, "R3 E0 indirect");
    gen_wr(8'hF0, 1'b0, 8'h96);
    gen_rd(8'hF0, 1'b0, "R4 F0 direct");
    gen_rd(8'hE0, 1'b0, "R4 E0 unaffected");
    gen_wr(8'hFF, 1'b1, 8'h42);
    gen_wr(8'hFF, 1'b0, 8'h00);
    gen_rd(8'hFF, 1'b1, "R5 write ignored FF");
    gen_rd(8'hFF, 1'b0, "R5 unimpl FF");

    wreg_wr(2'd2, 3'd5, 8'h66);
    gen_rd(8'h15, 1'b1, "R6 bank2 r5 at 15h");
    gen_wr(8'h0B, 1'b0, 8'h99);
    wreg_rd(2'd1, 3'd3, "R6 bank1 r3 at 0Bh");
    wreg_wr(2'd3, 3'd7, 8'h5E);
    wreg_rd(2'd3, 3'd7, "R6 bank3 r7");
    wreg_wr(2'd0, 3'd0, 8'h01);
    gen_rd(8'h00, 1'b0, "R6 bank0 r0 at 00h");

    push(8'h12);
    sp_check("R7 sp after push");
    gen_rd(8'h08, 1'b1, "R7 pushed byte at 08h");
    push(8'h34);
    pop("R8 pop last");
    sp_check("R8 sp after pop");
    pop("R8 pop first");
    sp_check("R8 sp back to 07");

    gen_rd(8'h81, 1'b0, "R10 sp via 81h");
    gen_wr(8'h81, 1'b0, 8'hFE);
    sp_check("R10 sp loaded");
    push(8'hAA);
    push(8'hBB);
    sp_check("R9 wrap to 00");
    gen_rd(8'h00, 1'b1, "R9 wrapped byte at 00h");
    gen_rd(8'hFF, 1'b1, "R7 upper stack byte");
    pop("R9 pop at 00");
    sp_check("R9 wrap to FF");

    // push beats read: only the push runs, no read result
    @(negedge clk); clr();
    push_req = 1'b1; wr_data = 8'hC7; rd_en = 1'b1; acc_addr = 8'h30;
    sp_m = sp_m + 8'd1; ram_m[sp_m] = 8'hC7;
    sp_check("R11 push wins");
    // pop beats register write: 1Fh must stay 5E
    @(negedge clk); clr();
    pop_req = 1'b1; reg_wr = 1'b1; bank_sel = 2'd3; reg_idx = 3'd7; wr_data = 8'hEE;
    expect_rd(ram_m[sp_m], "R11 pop wins");
    sp_m = sp_m - 8'd1;
    gen_rd(8'h1F, 1'b1, "R11 reg write dropped");
    // register op beats generic write
    @(negedge clk); clr();
    reg_rd = 1'b1; bank_sel = 2'd1; reg_idx = 3'd3; wr_en = 1'b1; acc_addr = 8'h30; wr_data = 8'h00;
    expect_rd(ram_m[8'h0B], "R11 reg wins");
    gen_rd(8'h30, 1'b0, "R11 generic write dropped");
    // write beats read in a generic access
    @(negedge clk); clr();
    wr_en = 1'b1; rd_en = 1'b1; acc_addr = 8'h50; acc_ind = 1'b1; wr_data = 8'h2D;
    ram_m[8'h50] = 8'h2D;
    gen_rd(8'h50, 1'b0, "R11 write over read");

    sp_check("R10 sp held");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11: %0d reads unanswered, expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule